// File: doc/BRIEF.md
# Configurable LUT Routing Fabric

This block is a small programmable logic fabric placed between eight peripheral-side terminals and eight pin-side terminals. Each channel index pairs one peripheral-side terminal with one pin-side terminal. The fabric holds one 3-input lookup table per channel. Each LUT input picks its source through a configurable code. A source can be a constant zero, a registered LUT output, or an input-direction terminal of the LUT's own half of the fabric. LUT0's first input is the exception: it can take the single-bit output of an external data unit.

Each terminal has a direction of its own. In bypass, the opposite-side signal passes straight through. In output, the terminal carries the LUT of the same channel index. In input, the terminal can feed LUTs, either directly or through a two-flop synchroniser on the fabric clock. Unused terminals carry zero. All configuration arrives on static configuration ports. LUT outputs are registered before they feed other LUT inputs, so the fabric has no combinational loops.

Top module: `lutfab_top`

## Requirements
- R1: A LUT output is bit {in2,in1,in0} of its 8-bit truth table, so in0 is the least significant index bit.
- R2: Selector code 0 gives a constant 0 to the LUT input, and so does any code above 16.
- R3: Codes 1 to 8 select the output of LUT (code-1) as it was registered at the previous rising clock edge.
- R4: On input 0, code 1 selects the data-unit output for LUT0 and selects constant 0 for LUTs 1 to 7.
- R5: Codes 9 to 12 select the pin-side terminal, and codes 13 to 16 select the peripheral-side terminal, at channel (half base + code offset). The half base is 0 for LUTs 0 to 3 and 4 for LUTs 4 to 7.
- R6: A terminal that a selector names feeds the LUT only when that terminal's direction is input (encoding 1). Otherwise it reads as 0.
- R7: When a terminal's sync bit is 1, a change on the terminal reaches the LUT after two rising clock edges. When the bit is 0, the change reaches the LUT in the same cycle.
- R8: While rst_n is low at a rising edge, the synchroniser flops and the LUT feedback registers clear to 0.
- R9: A pin-side terminal with direction bypass (encoding 0) drives pin_out from chip_in of the same channel. A peripheral-side terminal in bypass drives chip_out from pin_in.
- R10: A terminal with direction output (encoding 2) drives the combinational output of the LUT with its own channel index.
- R11: A terminal with direction input (1) or none (3) drives 0 on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| du_in | input | 1 | Data-unit output bit |
| pin_in | input | 8 | Values arriving from the pin-side terminals |
| chip_in | input | 8 | Values arriving from the peripheral-side terminals |
| pin_out | output | 8 | Values driven toward the pins |
| chip_out | output | 8 | Values driven toward the peripherals |
| cfg_tbl | input | 64 | Truth tables, 8 bits per LUT, LUT k at bits [8k+7:8k] |
| cfg_sel | input | 120 | Source codes, 5 bits per LUT input, input p of LUT k at base (3k+p)*5 |
| cfg_pin_dir | input | 16 | Pin-side directions, 2 bits per channel |
| cfg_chip_dir | input | 16 | Peripheral-side directions, 2 bits per channel |
| cfg_pin_sync | input | 8 | Per-channel sync select for pin-side inputs |
| cfg_chip_sync | input | 8 | Per-channel sync select for peripheral-side inputs |

## Verification
The assertions assume two things. First, rst_n is low for at least one rising edge before the fabric runs. Second, the terminals, du_in and the configuration do not change near a rising edge, so the values sampled there are settled. The stimulus meets both conditions. It drives every input on the falling edge and holds reset across two rising edges at the start. It also reads every combinational result shortly after the falling edge, well clear of the next rising edge.

// File: rtl/lutfab_pkg.sv
// Shared definitions for the LUT routing fabric.
// Assumes: LUTs are 3-input, so each truth table is 8 bits wide.
package lutfab_pkg;
    typedef enum logic [1:0] {
        DIR_BYPASS = 2'd0,
        DIR_IN     = 2'd1,
        DIR_OUT    = 2'd2,
        DIR_NONE   = 2'd3
    } term_dir_e;

    localparam int LUT_IN = 3;
    localparam int TBL_W  = 2 ** LUT_IN;
endpackage

// File: rtl/lutfab_sync2.sv
// Two-flop synchroniser bank for terminal inputs.
// Assumes: the fabric clock samples d; the reset is synchronous and active low.
module lutfab_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the terminal value through both stages; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    p_sync_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage2 == $past(stage1));

    p_sync_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stage1 == '0 && stage2 == '0));
endmodule

// File: rtl/lutfab_srcmux.sv
// Source selector for one LUT input.
// Assumes: the code map is 0 = zero, 1..NCH = LUT feedback, then HALF
// pin-side codes, then HALF peripheral-side codes; any other code gives zero.
// The caller passes only the terminals of the LUT's own half.
module lutfab_srcmux #(
    parameter int NCH  = 8,
    parameter int SELW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    input  logic [NCH-1:0]  lut_v,
    input  logic [NCH/2-1:0] pin_v,
    input  logic [NCH/2-1:0] chip_v,
    output logic            y
);
    localparam int HALF      = NCH / 2;
    localparam int CODE_PIN  = NCH + 1;
    localparam int CODE_CHIP = NCH + HALF + 1;
    localparam int CODE_MAX  = NCH + 2 * HALF;

    // Decode the selector code into one source bit; unknown codes give 0.
    always_comb begin
        int code;
        code = int'(sel);
        y = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            if (code == k + 1) y = lut_v[k];
        end
        for (int h = 0; h < HALF; h++) begin
            if (code == CODE_PIN + h)  y = pin_v[h];
            if (code == CODE_CHIP + h) y = chip_v[h];
        end
    end

    p_badsel_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 || sel > SELW'(CODE_MAX)) |-> y == 1'b0);
endmodule

// File: rtl/lutfab_lut.sv
// One 3-input lookup table with a registered copy of its output.
// Assumes: the combinational output goes to the terminals, and the registered
// copy is the only path back into LUT inputs, so the fabric has no loops.
module lutfab_lut
    import lutfab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_W-1:0]  tbl,
    input  logic [LUT_IN-1:0] idx,
    output logic              y,
    output logic              fb
);
    assign y = tbl[idx];

    // Hold the LUT result for one cycle so that it can feed other LUTs.
    always_ff @(posedge clk) begin
        if (!rst_n) fb <= 1'b0;
        else        fb <= y;
    end

    p_fb_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> fb == $past(y));
endmodule

// File: rtl/lutfab_term.sv
// Direction logic for one channel: its pin-side and peripheral-side terminals.
// Assumes: the direction codes come from lutfab_pkg, and the synchronised
// copies of the inputs come from the caller.
module lutfab_term
    import lutfab_pkg::*;
(
    input  logic [1:0] pin_dir,
    input  logic [1:0] chip_dir,
    input  logic       pin_sync,
    input  logic       chip_sync,
    input  logic       pin_in,
    input  logic       chip_in,
    input  logic       pin_in_s,
    input  logic       chip_in_s,
    input  logic       lut_y,
    output logic       pin_out,
    output logic       chip_out,
    output logic       pin_src,
    output logic       chip_src
);
    term_dir_e pd;
    term_dir_e cd;

    assign pd = term_dir_e'(pin_dir);
    assign cd = term_dir_e'(chip_dir);

    // Drive the pin side: pass-through in bypass, the LUT in output, else 0.
    always_comb begin
        case (pd)
            DIR_BYPASS: pin_out = chip_in;
            DIR_OUT:    pin_out = lut_y;
            default:    pin_out = 1'b0;
        endcase
    end

    // Drive the peripheral side with the same rule, mirrored.
    always_comb begin
        case (cd)
            DIR_BYPASS: chip_out = pin_in;
            DIR_OUT:    chip_out = lut_y;
            default:    chip_out = 1'b0;
        endcase
    end

    // Offer an input terminal to the LUTs, raw or synchronised.
    always_comb begin
        pin_src  = (pd == DIR_IN) ? (pin_sync  ? pin_in_s  : pin_in)  : 1'b0;
        chip_src = (cd == DIR_IN) ? (chip_sync ? chip_in_s : chip_in) : 1'b0;
    end
endmodule

// File: rtl/lutfab_top.sv
// Eight-channel LUT routing fabric between peripheral and pin terminals.
// Assumes: the configuration ports are static while the fabric runs.
// LUT k drives only channel k, and LUTs read terminals of their own half.
module lutfab_top
    import lutfab_pkg::*;
#(
    parameter  int NCH  = 8,
    localparam int SELW = $clog2(1 + 2 * NCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       du_in,
    input  logic [NCH-1:0]             pin_in,
    input  logic [NCH-1:0]             chip_in,
    output logic [NCH-1:0]             pin_out,
    output logic [NCH-1:0]             chip_out,
    input  logic [NCH*TBL_W-1:0]       cfg_tbl,
    input  logic [NCH*LUT_IN*SELW-1:0] cfg_sel,
    input  logic [2*NCH-1:0]           cfg_pin_dir,
    input  logic [2*NCH-1:0]           cfg_chip_dir,
    input  logic [NCH-1:0]             cfg_pin_sync,
    input  logic [NCH-1:0]             cfg_chip_sync
);
    localparam int HALF = NCH / 2;

    logic [NCH-1:0] pin_in_s;
    logic [NCH-1:0] chip_in_s;
    logic [NCH-1:0] pin_src;
    logic [NCH-1:0] chip_src;
    logic [NCH-1:0] lut_y;
    logic [NCH-1:0] lut_fb;

    lutfab_sync2 #(.W(NCH)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_in_s)
    );

    lutfab_sync2 #(.W(NCH)) u_chip_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chip_in),
        .q     (chip_in_s)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_term
        lutfab_term u_term (
            .pin_dir   (cfg_pin_dir[2*ch +: 2]),
            .chip_dir  (cfg_chip_dir[2*ch +: 2]),
            .pin_sync  (cfg_pin_sync[ch]),
            .chip_sync (cfg_chip_sync[ch]),
            .pin_in    (pin_in[ch]),
            .chip_in   (chip_in[ch]),
            .pin_in_s  (pin_in_s[ch]),
            .chip_in_s (chip_in_s[ch]),
            .lut_y     (lut_y[ch]),
            .pin_out   (pin_out[ch]),
            .chip_out  (chip_out[ch]),
            .pin_src   (pin_src[ch]),
            .chip_src  (chip_src[ch])
        );

        p_bypass_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
            term_dir_e'(cfg_pin_dir[2*ch +: 2]) == DIR_BYPASS |-> pin_out[ch] == chip_in[ch]);

        p_bypass_chip_r9: assert property (@(posedge clk) disable iff (!rst_n)
            term_dir_e'(cfg_chip_dir[2*ch +: 2]) == DIR_BYPASS |-> chip_out[ch] == pin_in[ch]);

        p_out_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            term_dir_e'(cfg_chip_dir[2*ch +: 2]) == DIR_OUT |-> chip_out[ch] == lut_y[ch]);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_lut
        localparam int BASE = (k / HALF) * HALF;
        logic [LUT_IN-1:0] ins;

        for (genvar p = 0; p < LUT_IN; p++) begin : g_port
            logic [NCH-1:0] fb_v;
            if (p == 0 && k == 0) begin : g_du
                assign fb_v = {lut_fb[NCH-1:1], du_in};
            end else if (p == 0) begin : g_noself
                assign fb_v = {lut_fb[NCH-1:1], 1'b0};
            end else begin : g_full
                assign fb_v = lut_fb;
            end

            lutfab_srcmux #(.NCH(NCH), .SELW(SELW)) u_mux (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (cfg_sel[(k*LUT_IN+p)*SELW +: SELW]),
                .lut_v  (fb_v),
                .pin_v  (pin_src[BASE +: HALF]),
                .chip_v (chip_src[BASE +: HALF]),
                .y      (ins[p])
            );
        end

        lutfab_lut u_lut (
            .clk   (clk),
            .rst_n (rst_n),
            .tbl   (cfg_tbl[k*TBL_W +: TBL_W]),
            .idx   (ins),
            .y     (lut_y[k]),
            .fb    (lut_fb[k])
        );

        if (k > 0) begin : g_chk
            p_du_only_lut0_r4: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_sel[(k*LUT_IN)*SELW +: SELW] == SELW'(1) |-> ins[0] == 1'b0);
        end
    end
endmodule

// File: tb/tb_lutfab_top.sv
module tb_lutfab_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         du_in = 1'b0;
    logic [7:0]   pin_in = '0;
    logic [7:0]   chip_in = '0;
    logic [7:0]   pin_out;
    logic [7:0]   chip_out;
    logic [63:0]  cfg_tbl = '0;
    logic [119:0] cfg_sel = '0;
    logic [15:0]  cfg_pin_dir = '0;
    logic [15:0]  cfg_chip_dir = '0;
    logic [7:0]   cfg_pin_sync = '0;
    logic [7:0]   cfg_chip_sync = '0;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    localparam logic [1:0] D_BYP = 2'd0, D_IN = 2'd1, D_OUT = 2'd2, D_NONE = 2'd3;

    lutfab_top dut (
        .clk(clk), .rst_n(rst_n), .du_in(du_in),
        .pin_in(pin_in), .chip_in(chip_in),
        .pin_out(pin_out), .chip_out(chip_out),
        .cfg_tbl(cfg_tbl), .cfg_sel(cfg_sel),
        .cfg_pin_dir(cfg_pin_dir), .cfg_chip_dir(cfg_chip_dir),
        .cfg_pin_sync(cfg_pin_sync), .cfg_chip_sync(cfg_chip_sync)
    );

    always #2.5ns clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1ns;
    endtask

    task automatic set_sel(int k, int p, int code);
        cfg_sel[(k*3+p)*5 +: 5] = 5'(code);
    endtask

    task automatic set_dir(int ch, logic [1:0] pd, logic [1:0] cd);
        cfg_pin_dir[2*ch +: 2]  = pd;
        cfg_chip_dir[2*ch +: 2] = cd;
    endtask

    task automatic cfg_clear();
        cfg_tbl = '0; cfg_sel = '0;
        cfg_pin_dir = '0; cfg_chip_dir = '0;
        cfg_pin_sync = '0; cfg_chip_sync = '0;
        pin_in = '0; chip_in = '0; du_in = 1'b0;
    endtask

    // R8, R3, R11: reset clears feedback; self-inverting loops toggle after release
    task automatic t_reset();
        for (int k = 0; k < 8; k++) begin
            cfg_tbl[k*8 +: 8] = 8'h33;
            set_sel(k, 1, k + 1);
            set_dir(k, D_OUT, D_NONE);
        end
        tick(); settle();
        check("R8 feedback cleared in reset", pin_out, 8'hFF);
        check("R11 none side quiet", chip_out, 8'h00);
        tick(); rst_n = 1'b1;
        tick(); settle();
        check("R3 loop after first edge", pin_out, 8'h00);
        tick(); settle();
        check("R3 loop after second edge", pin_out, 8'hFF);
    endtask

    // R1, R5, R6: truth tables over async pin inputs, both halves
    task automatic t_truth();
        logic [7:0] tbls [2] = '{8'h96, 8'hE8};
        tick(); cfg_clear();
        for (int c = 0; c < 3; c++) set_dir(c, D_IN, D_NONE);
        set_dir(3, D_OUT, D_NONE);
        set_sel(3, 0, 9); set_sel(3, 1, 10); set_sel(3, 2, 11);
        foreach (tbls[t]) begin
            cfg_tbl[3*8 +: 8] = tbls[t];
            for (int v = 0; v < 8; v++) begin
                tick(); pin_in[2:0] = 3'(v); settle();
                check("R1 lut3 table lookup", {7'b0, pin_out[3]}, {7'b0, tbls[t][v]});
            end
        end
        set_dir(4, D_IN, D_NONE); set_dir(5, D_NONE, D_IN); set_dir(7, D_OUT, D_NONE);
        set_sel(7, 0, 9); set_sel(7, 1, 14); cfg_tbl[7*8 +: 8] = 8'h66;
        for (int v = 0; v < 4; v++) begin
            tick();
            pin_in[4] = v[0]; chip_in[5] = v[1]; pin_in[0] = ~v[0];
            settle();
            check("R5 upper half terminal pick", {7'b0, pin_out[7]}, {7'b0, v[0] ^ v[1]});
        end
        tick(); set_dir(4, D_NONE, D_NONE); pin_in[4] = 1'b1; chip_in[5] = 1'b0; settle();
        check("R6 non-input terminal reads 0", {7'b0, pin_out[7]}, 8'h00);
        check("R11 none terminal drives 0", {7'b0, pin_out[4]}, 8'h00);
    endtask

    // R2: code 0 and codes above 16 read as zero
    task automatic t_badsel();
        tick(); cfg_clear();
        for (int c = 0; c < 3; c++) set_dir(c, D_IN, D_NONE);
        set_dir(3, D_OUT, D_NONE);
        cfg_tbl[3*8 +: 8] = 8'h01; pin_in = 8'hFF; settle();
        check("R2 code 0 is zero", {7'b0, pin_out[3]}, 8'h01);
        tick(); set_sel(3, 0, 20); set_sel(3, 1, 31); set_sel(3, 2, 17); settle();
        check("R2 codes above 16 are zero", {7'b0, pin_out[3]}, 8'h01);
        tick(); set_sel(3, 0, 9); settle();
        check("R5 code 9 reaches pin term 0", {7'b0, pin_out[3]}, 8'h00);
    endtask

    // R4, R3: data-unit bit on LUT0 input 0 only; feedback delay across LUTs
    task automatic t_du_feedback();
        tick(); cfg_clear();
        set_dir(0, D_OUT, D_NONE); set_dir(1, D_OUT, D_NONE); set_dir(2, D_OUT, D_NONE);
        set_dir(4, D_OUT, D_NONE); set_dir(5, D_OUT, D_NONE);
        set_sel(0, 0, 1); cfg_tbl[0*8 +: 8] = 8'hAA;
        set_sel(1, 0, 1); cfg_tbl[1*8 +: 8] = 8'h55;
        set_sel(2, 1, 1); cfg_tbl[2*8 +: 8] = 8'hCC;
        set_sel(4, 2, 1); cfg_tbl[4*8 +: 8] = 8'hF0;
        set_sel(5, 0, 3); cfg_tbl[5*8 +: 8] = 8'hAA;
        tick(); tick();
        du_in = 1'b1; settle();
        check("R4 lut0 input0 takes du", {7'b0, pin_out[0]}, 8'h01);
        check("R4 lut1 input0 code1 is zero", {7'b0, pin_out[1]}, 8'h01);
        check("R3 lut2 before edge", {7'b0, pin_out[2]}, 8'h00);
        tick(); settle();
        check("R3 lut2 after one edge", {7'b0, pin_out[2]}, 8'h01);
        check("R3 lut4 cross-half feedback", {7'b0, pin_out[4]}, 8'h01);
        check("R3 lut5 chain not yet", {7'b0, pin_out[5]}, 8'h00);
        check("R4 lut1 ignores lut0 feedback", {7'b0, pin_out[1]}, 8'h01);
        tick(); settle();
        check("R3 lut5 chain after two edges", {7'b0, pin_out[5]}, 8'h01);
        du_in = 1'b0; settle();
        check("R4 lut0 follows du low", {7'b0, pin_out[0]}, 8'h00);
    endtask

    // R7: synchronised input lags two edges; async input follows at once
    task automatic t_sync();
        tick(); cfg_clear();
        set_dir(1, D_NONE, D_IN); cfg_chip_sync[1] = 1'b1;
        set_dir(3, D_OUT, D_NONE);
        set_sel(3, 0, 14); cfg_tbl[3*8 +: 8] = 8'hAA;
        tick(); tick(); tick();
        chip_in[1] = 1'b1; settle();
        check("R7 sync rise before edges", {7'b0, pin_out[3]}, 8'h00);
        tick(); settle();
        check("R7 sync rise after one edge", {7'b0, pin_out[3]}, 8'h00);
        tick(); settle();
        check("R7 sync rise after two edges", {7'b0, pin_out[3]}, 8'h01);
        chip_in[1] = 1'b0; settle();
        check("R7 sync fall held", {7'b0, pin_out[3]}, 8'h01);
        tick(); tick(); settle();
        check("R7 sync fall after two edges", {7'b0, pin_out[3]}, 8'h00);
        cfg_chip_sync[1] = 1'b0; chip_in[1] = 1'b1; settle();
        check("R7 async follows at once", {7'b0, pin_out[3]}, 8'h01);
    endtask

    // R9, R10, R11: bypass passes through; output and inactive directions
    task automatic t_bypass();
        tick(); cfg_clear();
        pin_in = 8'hA5; chip_in = 8'h3C; settle();
        check("R9 pin side bypass", pin_out, 8'h3C);
        check("R9 chip side bypass", chip_out, 8'hA5);
        tick(); pin_in = 8'h5A; chip_in = 8'hC3; settle();
        check("R9 bypass second pattern", {pin_out, chip_out} == 16'hC35A ? 8'h01 : 8'h00, 8'h01);
        tick(); pin_in = '0; chip_in = '0;
        set_dir(6, D_NONE, D_OUT); cfg_tbl[6*8 +: 8] = 8'hFF; settle();
        check("R10 chip out from lut6", {7'b0, chip_out[6]}, 8'h01);
        check("R11 pin none drives 0", {7'b0, pin_out[6]}, 8'h00);
        tick(); cfg_tbl[6*8 +: 8] = 8'h00; settle();
        check("R10 chip out follows table", {7'b0, chip_out[6]}, 8'h00);
        tick(); set_dir(2, D_IN, D_NONE); pin_in[2] = 1'b1; chip_in[2] = 1'b1; settle();
        check("R11 input and none drive 0", {6'b0, pin_out[2], chip_out[2]}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_truth();
        t_badsel();
        t_du_feedback();
        t_sync();
        t_bypass();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule